// File: doc/BRIEF.md
# Four-Lane SD Card Block Write Transmitter

This block moves a run of data blocks from a byte-wide ready/valid source onto the four data lines of an SD card bus. For each block it first drives all four lines high. It then sends a zero start nibble, the payload nibbles and a sixteen-clock trailer that holds an independent CRC16 for every lane. A closing all-ones nibble ends the block. After that it releases the lines and listens on lane 0 for the card's three-bit status token.

An accepted token lets the block wait out the card's busy period and then start the next block, until the programmed count is reached. A rejected token, a token that never appears, or an overall time limit stops the run at once, returns the lines to inputs and reports a distinct result code. One system clock cycle in which `bus_tick` is high equals one card bus clock. While the source has no byte ready, the block withholds the bus clock rather than sending stale data.

Top module: `sd4_write_tx`

## Requirements
- R1: After reset the block is idle: `busy`, `dat_oe`, `wr_ready` and `done` are 0, `result` is 0 and `blocks_ok` is 0.
- R2: Each block is sent with `dat_oe` high as these bus clocks in order: one all-ones lead nibble, one zero start nibble, then 2*BLOCK_BYTES data nibbles, then 16 CRC nibbles, then one all-ones end nibble. Each byte goes out high nibble first, and bit i of a nibble is driven on lane i.
- R3: The CRC nibbles carry, for each lane separately, the CRC16 with generator x^16+x^12+x^5+1 and a zero start value over that lane's data bits. Each lane's CRC is sent most significant bit first.
- R4: `wr_ready` is high only during the data phase when a new byte is needed. While `wr_ready` is high and `wr_valid` is low, `bus_tick` stays low and the frame does not advance.
- R5: After the end nibble, `dat_oe` is low. Each bus clock samples `d0_in`, and ones are skipped until the first 0 (the start bit). The next three samples form the status code, first sample as the most significant bit.
- R6: Status 010 is the accepted code. After it, the next bus clock (the token end bit) is skipped, and the block then waits while `d0_in` is 0. The first 1 either starts the next block's lead nibble on the next cycle or, when the count is reached, ends the run with result 0. A run ends with `busy` falling and a one-cycle `done` pulse in the same cycle.
- R7: Status 101 ends the run with result 1 (card CRC error) and `dat_oe` low.
- R8: Status 110, and every other code except 010 and 101, ends the run with result 2 (write failure).
- R9: If no start bit is seen within TOKEN_WINDOW bus clocks after the end nibble, the run ends with result 2. A start bit on the last clock of the window is still accepted.
- R10: `blocks_ok` holds the number of blocks the card accepted in the current or last run.
- R11: A run that has not ended after TIMEOUT_CYCLES cycles of `busy` ends with result 3 and `dat_oe` low. `busy` is high for exactly TIMEOUT_CYCLES cycles.
- R12: A start with `block_count` of 0 drives nothing. It gives `done` with result 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run, sampled while idle |
| block_count | input | COUNT_W | Number of blocks in the run |
| wr_data | input | 8 | Payload byte |
| wr_valid | input | 1 | Payload byte present |
| wr_ready | output | 1 | Payload byte taken at this edge when valid |
| dat_out | output | 4 | Values driven on the four data lanes |
| dat_oe | output | 1 | Lanes driven by the block when high |
| bus_tick | output | 1 | This cycle is one card bus clock |
| d0_in | input | 1 | Lane 0 as seen from the card side |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| result | output | 2 | 0 ok, 1 card CRC error, 2 write failure, 3 timeout |
| blocks_ok | output | COUNT_W | Blocks accepted by the card |

## Verification
The bench builds the block with BLOCK_BYTES=4, TOKEN_WINDOW=6, TIMEOUT_CYCLES=400 and COUNT_W=3. This makes a frame only 27 bus clocks long, so it can sweep every one of the eight status codes, both edges of the token search window, runs of zero to three blocks with and without source stalls, and failures on a middle or final block. The small time limit lets a stalled source reach the timeout, so the cycle count of R11 can be checked exactly. Per-lane CRCs and framing are rebuilt in the bench by long division of each lane's bit string.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_CRC_ERR = 2'd1,
    RES_WR_FAIL = 2'd2,
    RES_TIMEOUT = 2'd3
  } sdw_result_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SOF,
    ST_DATA,
    ST_CRC,
    ST_EOF,
    ST_TOKEN,
    ST_BUSY
  } sdw_state_e;

  localparam logic [2:0]  TOKEN_ACCEPTED = 3'b010;
  localparam logic [2:0]  TOKEN_CRC_BAD  = 3'b101;
  localparam int unsigned CRC_BITS       = 16;
  localparam logic [15:0] CRC_POLY       = 16'h1021;

endpackage

// File: rtl/sdw_nibble_src.sv
// Splits incoming payload bytes into nibbles, high half first.
module sdw_nibble_src (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       nib_valid,
  output logic [3:0] nib
);

  logic       half_q, half_d;
  logic [3:0] low_q, low_d;
  logic       take;

  always_comb begin
    in_ready  = active & ~half_q;
    take      = in_ready & in_valid;
    nib_valid = active & (half_q | in_valid);
    nib       = half_q ? low_q : in_data[7:4];
    half_d    = half_q;
    low_d     = low_q;
    if (!active) begin
      half_d = 1'b0;
    end else if (take) begin
      half_d = 1'b1;
      low_d  = in_data[3:0];
    end else if (half_q) begin
      half_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      low_q  <= '0;
    end else begin
      half_q <= half_d;
      low_q  <= low_d;
    end
  end

  // After a byte is taken the low half goes out next, without a new request.
  assert_low_half_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!in_ready && (nib_valid || !active)))
    else $error("low nibble did not follow its byte");

endmodule

// File: rtl/sdw_lane_crc.sv
// Serial CRC for one data lane: accumulate, then shift out MSB first.
module sdw_lane_crc #(
  parameter int unsigned       WIDTH = 16,
  parameter logic [WIDTH-1:0]  POLY  = 16'h1021
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic din,
  input  logic shift,
  output logic crc_msb
);

  logic [WIDTH-1:0] crc_q, crc_d;
  logic             fb;
  logic             en;

  always_comb begin
    fb    = din ^ crc_q[WIDTH-1];
    en    = clr | adv | shift;
    crc_d = crc_q;
    if (clr) begin
      crc_d = '0;
    end else if (adv) begin
      crc_d = {crc_q[WIDTH-2:0], 1'b0} ^ (POLY & {WIDTH{fb}});
    end else if (shift) begin
      crc_d = {crc_q[WIDTH-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (en) begin
      crc_q <= crc_d;
    end
  end

  assign crc_msb = crc_q[WIDTH-1];

endmodule

// File: rtl/sdw_token_rx.sv
// Searches lane 0 for the status start bit and collects the three code bits.
module sdw_token_rx #(
  parameter int unsigned WINDOW = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       d0,
  output logic       tok_done,
  output logic       tok_found,
  output logic [2:0] tok_code
);

  localparam int unsigned WIN_W = (WINDOW > 1) ? $clog2(WINDOW + 1) : 1;

  logic [WIN_W-1:0] win_q, win_d;
  logic             found_q, found_d;
  logic [1:0]       bits_q, bits_d;
  logic [1:0]       sh_q, sh_d;

  always_comb begin
    win_d     = win_q;
    found_d   = found_q;
    bits_d    = bits_q;
    sh_d      = sh_q;
    tok_done  = 1'b0;
    tok_found = 1'b0;
    tok_code  = {sh_q, d0};
    if (!en) begin
      win_d   = '0;
      found_d = 1'b0;
      bits_d  = '0;
      sh_d    = '0;
    end else if (!found_q) begin
      if (!d0) begin
        found_d = 1'b1;
        bits_d  = '0;
      end else if (win_q == WIN_W'(WINDOW - 1)) begin
        tok_done = 1'b1;
      end else begin
        win_d = win_q + 1'b1;
      end
    end else begin
      sh_d   = {sh_q[0], d0};
      bits_d = bits_q + 1'b1;
      if (bits_q == 2'd2) begin
        tok_done  = 1'b1;
        tok_found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= '0;
      found_q <= 1'b0;
      bits_q  <= '0;
      sh_q    <= '0;
    end else begin
      win_q   <= win_d;
      found_q <= found_d;
      bits_q  <= bits_d;
      sh_q    <= sh_d;
    end
  end

  // The search never runs past the window.
  assert_search_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !found_q) |-> (win_q < WIN_W'(WINDOW)))
    else $error("token search ran past its window");

endmodule

// File: rtl/sd4_write_tx.sv
module sd4_write_tx
  import sdw_pkg::*;
#(
  parameter int unsigned BLOCK_BYTES    = 512,
  parameter int unsigned COUNT_W        = 16,
  parameter int unsigned TOKEN_WINDOW   = 32,
  parameter int unsigned TIMEOUT_CYCLES = 2000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [COUNT_W-1:0] block_count,
  input  logic [7:0]         wr_data,
  input  logic               wr_valid,
  output logic               wr_ready,
  output logic [3:0]         dat_out,
  output logic               dat_oe,
  output logic               bus_tick,
  input  logic               d0_in,
  output logic               busy,
  output logic               done,
  output logic [1:0]         result,
  output logic [COUNT_W-1:0] blocks_ok
);

  localparam int unsigned LANES     = 4;
  localparam int unsigned DATA_NIBS = 2 * BLOCK_BYTES;
  localparam int unsigned CRC_NIBS  = CRC_BITS;
  localparam int unsigned MAX_NIBS  = (DATA_NIBS > CRC_NIBS) ? DATA_NIBS : CRC_NIBS;
  localparam int unsigned NIB_W     = $clog2(MAX_NIBS);
  localparam int unsigned TMO_W     = $clog2(TIMEOUT_CYCLES);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  sdw_state_e         state_q, state_d;
  logic [NIB_W-1:0]   nib_q, nib_d;
  logic [COUNT_W-1:0] blk_q, blk_d, total_q, total_d, blk_inc;
  logic [TMO_W-1:0]   tmo_q, tmo_d;
  sdw_result_e        res_q, res_d;
  logic               done_q, done_d;
  logic               skip_q, skip_d;

  logic               fin;
  sdw_result_e        fin_res;

  // Payload nibble source
  logic       data_phase;
  logic       nib_valid;
  logic [3:0] nib;

  assign data_phase = (state_q == ST_DATA);

  sdw_nibble_src u_src (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .active    (data_phase),
    .in_data   (wr_data),
    .in_valid  (wr_valid),
    .in_ready  (wr_ready),
    .nib_valid (nib_valid),
    .nib       (nib)
  );

  // One CRC engine per lane
  logic [LANES-1:0] crc_msb;
  logic             crc_clr, crc_adv, crc_shift;

  assign crc_clr   = (state_q == ST_SOF);
  assign crc_adv   = data_phase & nib_valid;
  assign crc_shift = (state_q == ST_CRC);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sdw_lane_crc #(
      .WIDTH (CRC_BITS),
      .POLY  (CRC_POLY)
    ) u_crc (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .clr     (crc_clr),
      .adv     (crc_adv),
      .din     (nib[g]),
      .shift   (crc_shift),
      .crc_msb (crc_msb[g])
    );
  end

  // Status token receiver
  logic       tok_en, tok_done, tok_found;
  logic [2:0] tok_code;

  assign tok_en = (state_q == ST_TOKEN);

  sdw_token_rx #(
    .WINDOW (TOKEN_WINDOW)
  ) u_tok (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .en        (tok_en),
    .d0        (d0_in),
    .tok_done  (tok_done),
    .tok_found (tok_found),
    .tok_code  (tok_code)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    nib_d   = nib_q;
    blk_d   = blk_q;
    total_d = total_q;
    tmo_d   = tmo_q;
    res_d   = res_q;
    skip_d  = skip_q;
    done_d  = 1'b0;
    fin     = 1'b0;
    fin_res = RES_OK;
    blk_inc = blk_q + 1'b1;

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          total_d = block_count;
          blk_d   = '0;
          tmo_d   = '0;
          if (block_count == '0) begin
            done_d = 1'b1;
            res_d  = RES_OK;
          end else begin
            state_d = ST_LEAD;
          end
        end
      end
      ST_LEAD: state_d = ST_SOF;
      ST_SOF: begin
        state_d = ST_DATA;
        nib_d   = '0;
      end
      ST_DATA: begin
        if (nib_valid) begin
          if (nib_q == NIB_W'(DATA_NIBS - 1)) begin
            state_d = ST_CRC;
            nib_d   = '0;
          end else begin
            nib_d = nib_q + 1'b1;
          end
        end
      end
      ST_CRC: begin
        if (nib_q == NIB_W'(CRC_NIBS - 1)) begin
          state_d = ST_EOF;
        end else begin
          nib_d = nib_q + 1'b1;
        end
      end
      ST_EOF: state_d = ST_TOKEN;
      ST_TOKEN: begin
        if (tok_done) begin
          if (tok_found && (tok_code == TOKEN_ACCEPTED)) begin
            state_d = ST_BUSY;
            skip_d  = 1'b1;
          end else begin
            fin     = 1'b1;
            fin_res = (tok_found && (tok_code == TOKEN_CRC_BAD)) ? RES_CRC_ERR : RES_WR_FAIL;
          end
        end
      end
      ST_BUSY: begin
        if (skip_q) begin
          skip_d = 1'b0;
        end else if (d0_in) begin
          blk_d = blk_inc;
          if (blk_inc == total_q) begin
            fin     = 1'b1;
            fin_res = RES_OK;
          end else begin
            state_d = ST_LEAD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (state_q != ST_IDLE) begin
      if (tmo_q == TMO_W'(TIMEOUT_CYCLES - 1)) begin
        fin     = 1'b1;
        fin_res = RES_TIMEOUT;
      end else begin
        tmo_d = tmo_q + 1'b1;
      end
    end

    if (fin) begin
      state_d = ST_IDLE;
      done_d  = 1'b1;
      res_d   = fin_res;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_IDLE;
      nib_q   <= '0;
      blk_q   <= '0;
      total_q <= '0;
      tmo_q   <= '0;
      res_q   <= RES_OK;
      done_q  <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      nib_q   <= nib_d;
      blk_q   <= blk_d;
      total_q <= total_d;
      tmo_q   <= tmo_d;
      res_q   <= res_d;
      done_q  <= done_d;
      skip_q  <= skip_d;
    end
  end

  // Output decode
  always_comb begin
    dat_oe = (state_q == ST_LEAD) || (state_q == ST_SOF) || (state_q == ST_DATA) ||
             (state_q == ST_CRC)  || (state_q == ST_EOF);
    case (state_q)
      ST_SOF:  dat_out = 4'h0;
      ST_DATA: dat_out = nib;
      ST_CRC:  dat_out = crc_msb;
      default: dat_out = 4'hF;
    endcase
    bus_tick = (state_q != ST_IDLE) && !(data_phase && !nib_valid);
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign result    = res_q;
  assign blocks_ok = blk_q;

  // A run always ends with the done pulse.
  assert_done_on_release_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(busy) |-> done)
    else $error("busy dropped without done");

  // Payload is only requested while the lanes are driven.
  assert_ready_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_ready |-> dat_oe)
    else $error("payload requested outside a frame");

  // The accepted-block count stays below the programmed total during a run.
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    busy |-> (blocks_ok < total_q))
    else $error("accepted count reached total while running");

  // An accepted token leads into the busy wait.
  assert_accept_to_wait_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (tok_en && tok_done && tok_found && (tok_code == TOKEN_ACCEPTED))
      |=> ((state_q == ST_BUSY) || (res_q == RES_TIMEOUT)))
    else $error("accepted token did not lead to busy wait");

  // Failures release the lanes.
  assert_release_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (done && (result != RES_OK)) |-> !dat_oe)
    else $error("lanes still driven after failure");

endmodule

// File: tb/sd4_write_tx_tb_top.sv
`timescale 1ns/1ps
module sd4_write_tx_tb_top;

  localparam int BB    = 4;
  localparam int CW    = 3;
  localparam int WIN   = 6;
  localparam int TMO   = 400;
  localparam int DN    = 2 * BB;
  localparam int FRAME = DN + 19;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [CW-1:0] block_count;
  logic [7:0]    wr_data;
  logic          wr_valid;
  logic          wr_ready;
  logic [3:0]    dat_out;
  logic          dat_oe;
  logic          bus_tick;
  logic          d0_in;
  logic          busy;
  logic          done;
  logic [1:0]    result;
  logic [CW-1:0] blocks_ok;

  sd4_write_tx #(
    .BLOCK_BYTES    (BB),
    .COUNT_W        (CW),
    .TOKEN_WINDOW   (WIN),
    .TIMEOUT_CYCLES (TMO)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .block_count (block_count),
    .wr_data     (wr_data),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .dat_out     (dat_out),
    .dat_oe      (dat_oe),
    .bus_tick    (bus_tick),
    .d0_in       (d0_in),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .blocks_ok   (blocks_ok)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  // Card model and payload description
  int tok_code [4];
  int lead     [4];
  int bsy      [4];
  bit miss     [4];
  int seed_g;
  logic [3:0] nibs [64];

  function automatic logic [7:0] byte_of(input int idx);
    if (seed_g == 0) return 8'h00;
    return 8'((seed_g * 37 + idx * 29 + 11) ^ (idx * seed_g * 5));
  endfunction

  function automatic logic [3:0] nib_of(input int blk, input int n);
    logic [7:0] b;
    b = byte_of(blk * BB + n / 2);
    return (n % 2 == 0) ? b[7:4] : b[3:0];
  endfunction

  // CRC as remainder of (lane bits * x^16) divided by the generator.
  function automatic logic [15:0] lane_crc(input int blk, input int lane);
    logic [DN+15:0] r;
    logic [3:0]     nv;
    r = '0;
    for (int n = 0; n < DN; n++) begin
      nv = nib_of(blk, n);
      r[DN+15-n] = nv[lane];
    end
    for (int k = DN + 15; k >= 16; k--) begin
      if (r[k]) r[k -: 17] = r[k -: 17] ^ 17'h11021;
    end
    return r[15:0];
  endfunction

  function automatic logic resp_bit(input int b, input int k);
    int l;
    if (miss[b]) return 1'b1;
    l = lead[b];
    if (k < l)      return 1'b1;
    if (k == l)     return 1'b0;
    if (k <= l + 3) return 1'(tok_code[b] >> (2 - (k - l - 1)));
    if (k == l + 4) return 1'b1;
    if (k < l + 5 + bsy[b]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int exp_rx(input int b);
    if (miss[b]) return WIN;
    if (tok_code[b] == 2) return lead[b] + bsy[b] + 6;
    return lead[b] + 4;
  endfunction

  task automatic check_frame(input int b, input int nn);
    int bad_d;
    int bad_c;
    logic [15:0] crc [4];
    logic [3:0]  en;
    chk(nn == FRAME, "R2", "frame length", nn, FRAME);
    chk(nibs[0] == 4'hF && nibs[1] == 4'h0 && nibs[FRAME-1] == 4'hF, "R2", "lead/start/end nibbles",
        int'({nibs[0], nibs[1], nibs[FRAME-1]}), 'hF0F);
    bad_d = 0;
    for (int n = 0; n < DN; n++) if (nibs[2+n] !== nib_of(b, n)) bad_d++;
    chk(bad_d == 0, "R2", "data nibble mismatches", bad_d, 0);
    for (int l = 0; l < 4; l++) crc[l] = lane_crc(b, l);
    bad_c = 0;
    for (int i = 0; i < 16; i++) begin
      for (int l = 0; l < 4; l++) en[l] = crc[l][15-i];
      if (nibs[2+DN+i] !== en) bad_c++;
    end
    chk(bad_c == 0, "R3", "CRC nibble mismatches", bad_c, 0);
  endtask

  task automatic run(input int nblk, input bit stall);
    int exp_res, exp_blk, frames, nib_n, rx_cnt, cur, bidx, stall_err, ready_err;
    bit in_frame, seen_done;
    string rq;
    exp_res = 0; exp_blk = nblk;
    for (int b = 0; b < nblk; b++) begin
      if (miss[b])                 begin exp_res = 2; exp_blk = b; break; end
      else if (tok_code[b] == 2)   continue;
      else if (tok_code[b] == 5)   begin exp_res = 1; exp_blk = b; break; end
      else                         begin exp_res = 2; exp_blk = b; break; end
    end
    rq = (exp_res == 0) ? "R6" : (exp_res == 1) ? "R7" : (exp_blk < nblk && miss[exp_blk]) ? "R9" : "R8";
    frames = 0; nib_n = 0; rx_cnt = 0; cur = 0; bidx = 0; stall_err = 0; ready_err = 0;
    in_frame = 0; seen_done = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      start       = (c == 0);
      block_count = CW'(nblk);
      wr_valid    = stall ? ((c % 3) != 1) : 1'b1;
      wr_data     = byte_of(bidx);
      d0_in       = (frames == 0) ? 1'b1 : resp_bit(cur, rx_cnt);
      #1;
      if (c > 0 && done) begin seen_done = 1; break; end
      if (!wr_valid && wr_ready && bus_tick) stall_err++;
      if (wr_ready && !dat_oe) ready_err++;
      if (wr_ready && wr_valid) bidx++;
      if (bus_tick && dat_oe) begin
        if (!in_frame) begin
          if (frames > 0) chk(rx_cnt == exp_rx(cur), "R6", "clocks from end nibble to next lead", rx_cnt, exp_rx(cur));
          in_frame = 1; nib_n = 0; frames++; cur = frames - 1; rx_cnt = 0;
        end
        if (nib_n < 64) nibs[nib_n] = dat_out;
        nib_n++;
      end
      if (bus_tick && !dat_oe) begin
        if (in_frame) begin in_frame = 0; check_frame(cur, nib_n); end
        rx_cnt++;
      end
    end
    start = 1'b0;
    chk(seen_done, rq, "done seen", int'(seen_done), 1);
    chk(result == 2'(exp_res), rq, "result code", int'(result), exp_res);
    chk(blocks_ok == CW'(exp_blk), "R10", "accepted blocks", int'(blocks_ok), exp_blk);
    chk(!dat_oe && !busy, "R7", "lanes released at end", int'({dat_oe, busy}), 0);
    if (frames > 0) chk(rx_cnt == exp_rx(cur), "R5", "clocks after last end nibble", rx_cnt, exp_rx(cur));
    chk(frames == exp_blk + ((exp_res != 0) ? 1 : 0), rq, "frames sent", frames, exp_blk + ((exp_res != 0) ? 1 : 0));
    chk(stall_err == 0, "R4", "bus clock while source stalled", stall_err, 0);
    chk(ready_err == 0, "R4", "ready outside frame", ready_err, 0);
    @(negedge clk); #1;
    chk(!done, "R6", "done is a single pulse", int'(done), 0);
  endtask

  task automatic set_blk(input int b, input int code, input int l, input int bl, input bit m);
    tok_code[b] = code; lead[b] = l; bsy[b] = bl; miss[b] = m;
  endtask

  task automatic run_timeout();
    int busy_cycles, bidx;
    bit seen_done;
    busy_cycles = 0; bidx = 0; seen_done = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      start       = (c == 0);
      block_count = CW'(2);
      wr_valid    = (bidx < 3);
      wr_data     = byte_of(bidx);
      d0_in       = 1'b1;
      #1;
      if (c > 0 && done) begin seen_done = 1; break; end
      if (wr_ready && wr_valid) bidx++;
      if (busy) busy_cycles++;
    end
    start = 1'b0;
    chk(seen_done, "R11", "done after stall", int'(seen_done), 1);
    chk(busy_cycles == TMO, "R11", "busy cycles before timeout", busy_cycles, TMO);
    chk(result == 2'd3, "R11", "timeout code", int'(result), 3);
    chk(!dat_oe, "R11", "lanes released", int'(dat_oe), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; block_count = '0; wr_data = '0; wr_valid = 1'b0; d0_in = 1'b1;
    seed_g = 1;
    for (int b = 0; b < 4; b++) set_blk(b, 2, 1, 1, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!busy && !dat_oe && !wr_ready && !done, "R1", "idle flags", int'({busy, dat_oe, wr_ready, done}), 0);
    chk(result == 2'd0 && blocks_ok == '0, "R1", "result and count", int'({result, blocks_ok}), 0);

    // Every status code on a single block
    for (int code = 0; code < 8; code++) begin
      seed_g = code + 1;
      set_blk(0, code, 1, 2, 1'b0);
      run(1, 1'b0);
    end

    // Search window edges
    seed_g = 21; set_blk(0, 2, WIN - 1, 0, 1'b0); run(1, 1'b0);
    seed_g = 22; set_blk(0, 2, WIN, 0, 1'b1);     run(1, 1'b0);

    // Multi-block runs, with and without source stalls
    for (int nb = 1; nb <= 3; nb++) begin
      for (int s = 0; s < 2; s++) begin
        seed_g = nb * 10 + s + 3;
        for (int b = 0; b < 4; b++) set_blk(b, 2, (b + nb) % 4, (b * 2 + s) % 5, 1'b0);
        run(nb, 1'(s));
      end
    end

    // Zero payload
    seed_g = 0;
    set_blk(0, 2, 0, 0, 1'b0); set_blk(1, 2, 2, 3, 1'b0);
    run(2, 1'b0);

    // Failures after accepted blocks
    seed_g = 41;
    set_blk(0, 2, 1, 1, 1'b0); set_blk(1, 5, 0, 0, 1'b0); set_blk(2, 2, 0, 0, 1'b0);
    run(3, 1'b1);
    seed_g = 42;
    set_blk(0, 2, 0, 2, 1'b0); set_blk(1, 2, 3, 0, 1'b0); set_blk(2, 6, 1, 0, 1'b0);
    run(3, 1'b0);
    seed_g = 43;
    set_blk(0, 2, 2, 1, 1'b0); set_blk(1, 2, 0, 0, 1'b1);
    run(2, 1'b0);

    // Zero count after an error run: result returns to 0
    @(negedge clk);
    start = 1'b1; block_count = '0;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(done && result == 2'd0, "R12", "immediate done with ok", int'({done, result}), 4);
    chk(!busy && !dat_oe && blocks_ok == '0, "R12", "nothing driven", int'({busy, dat_oe, blocks_ok}), 0);

    // Stalled source runs into the time limit
    seed_g = 51;
    run_timeout();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule